// File: doc/BRIEF.md
# SDRAM Read Burst Data Sequencer

This block runs the data phase of a read from a synchronous DRAM. When a read is issued, it takes the bank and starting column and latches the burst settings that apply at that moment: burst length, whether the burst is sequential or interleaved, and the CAS latency. It then produces one column address per clock for every word of the burst. It also delays a valid flag for each word by the CAS latency. When that flag comes out of the delay, the block captures the 16-bit data bus and labels the word with its column and bank.

A controller places the block next to its command issue logic. It pulses `rd_cmd` in the same cycle that the read goes out to the memory. It pulses `burst_stop` when a burst-terminate or another non-read command cuts the burst short. A full-page burst keeps running until it is stopped or replaced, and it wraps from the last column to column 0. A read that arrives during a burst replaces that burst. Words that were already requested are still captured. The new words follow them with no overlap.

Top module: `sdram_rd_burst_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after release, `col_vld` and `data_vld` are low.
- R2: `cas_lat` sets the latency from the read to its first captured word. Values 0, 1 and 2 give 2 clocks and value 3 gives 3 clocks. For a read sampled at edge T, `data_vld` first rises after edge T+CL.
- R3: `bl_sel` values 0, 1, 2 and 3 give fixed bursts of 1, 2, 4 and 8 words. One column is presented per clock with no gaps, starting in the cycle after the read. `col_vld` falls after the last word.
- R4: When `intlv_mode`=0, a fixed burst counts upward from the starting column. It wraps inside the block of columns aligned to the burst length. The column bits above the block never change.
- R5: When `intlv_mode`=1, the low log2(length) column bits of word k equal the starting column's low bits XOR k.
- R6: Any `bl_sel` with bit 2 set selects a full-page burst. Its column increases by one each clock, wrapping from 255 to 0, and it never ends by itself. `intlv_mode` has no effect on it.
- R7: A `burst_stop` sampled at an edge ends column issue from that edge onward. Words issued before it are still captured CL clocks after their column was presented.
- R8: A read sampled during a burst replaces it from the next cycle. The old burst's captured words come first, then the new burst's words, with no cycle that carries both.
- R9: `bl_sel`, `intlv_mode` and `cas_lat` are sampled only with `rd_cmd`. Changing them during a burst does not alter its columns, length or data timing.
- R10: Each capture loads `data_out` with `dq_in` as it stood at the capturing edge. It tags the word in `data_col` and `data_bank` with the column and bank presented CL clocks earlier. The captured values are held while `data_vld` is low.
- R11: When `rd_cmd` and `burst_stop` are high in the same cycle, the read wins and a new burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_cmd | input | 1 | Read issued this cycle |
| rd_bank | input | 2 | Bank of the read |
| rd_col | input | 8 | Starting column of the read |
| burst_stop | input | 1 | Terminate the burst in progress |
| bl_sel | input | 3 | Burst length code (0..3 fixed 1/2/4/8, bit 2 set: full page) |
| intlv_mode | input | 1 | 1: interleaved order, 0: sequential |
| cas_lat | input | 2 | CAS latency in clocks (2 or 3) |
| dq_in | input | 16 | Memory data bus |
| col_vld | output | 1 | A column of the burst is presented this cycle |
| col_addr | output | 8 | Column of the current word |
| col_bank | output | 2 | Bank of the current word |
| data_vld | output | 1 | A captured word is on `data_out` |
| data_out | output | 16 | Captured data word |
| data_col | output | 8 | Column of the captured word |
| data_bank | output | 2 | Bank of the captured word |

## Verification
Several properties are checked by assertions on every cycle:
- A fixed burst's word counter never goes past the last word.
- A stop with no read ends the column stream on the next cycle.
- A read always restarts at word 0.
- A full-page burst steps its column by exactly one per clock.
- Every captured word follows a presented column by exactly the latched CAS latency.

Other behaviour is shown only by the bench's scenarios, which compare every cycle against a behavioural model:
- the actual column orders, including the aligned-block wrap, the XOR pattern and the 255-to-0 rollover;
- the data values captured off the bus;
- the clamping of latency codes;
- the fact that mode changes in the middle of a burst have no effect.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

    // Burst settings latched with each read.
    typedef struct packed {
        logic       full;      // full-page burst
        logic [1:0] len_log2;  // fixed length = 1 << len_log2
        logic       intlv;     // interleaved order (fixed lengths only)
    } burst_mode_t;

    function automatic burst_mode_t decode_mode(input logic [2:0] sel, input logic intlv);
        burst_mode_t m;
        m.full     = sel[2];
        m.len_log2 = sel[1:0];
        m.intlv    = intlv & ~sel[2];
        return m;
    endfunction

endpackage

// File: rtl/sdram_rd_burst_ctl.sv
module sdram_rd_burst_ctl
    import sdram_rd_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int CL_W   = 2,
    parameter int MIN_CL = 2,
    parameter int MAX_CL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_cmd,
    input  logic              burst_stop,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    input  logic [2:0]        bl_sel,
    input  logic              intlv_mode,
    input  logic [CL_W-1:0]   cas_lat,
    output logic              act,
    output logic [COL_W-1:0]  cnt,
    output logic [COL_W-1:0]  start,
    output logic [BANK_W-1:0] bank,
    output burst_mode_t       mode,
    output logic [CL_W-1:0]   cl
);

    localparam logic [CL_W-1:0] CL_LO = CL_W'(MIN_CL);
    localparam logic [CL_W-1:0] CL_HI = CL_W'(MAX_CL);

    typedef struct packed {
        logic              act;
        logic [COL_W-1:0]  cnt;
        logic [COL_W-1:0]  start;
        logic [BANK_W-1:0] bank;
        burst_mode_t       mode;
        logic [CL_W-1:0]   cl;
    } st_t;

    st_t st_d, st_q;
    logic [COL_W-1:0] last_idx;
    logic [CL_W-1:0]  cl_clamped;

    always_comb begin
        last_idx = (COL_W'(1) << st_q.mode.len_log2) - COL_W'(1);
        if (cas_lat < CL_LO)      cl_clamped = CL_LO;
        else if (cas_lat > CL_HI) cl_clamped = CL_HI;
        else                      cl_clamped = cas_lat;

        st_d = st_q;
        if (rd_cmd) begin
            st_d.act   = 1'b1;
            st_d.cnt   = '0;
            st_d.start = rd_col;
            st_d.bank  = rd_bank;
            st_d.mode  = decode_mode(bl_sel, intlv_mode);
            st_d.cl    = cl_clamped;
        end else if (burst_stop) begin
            st_d.act = 1'b0;
        end else if (st_q.act) begin
            if (!st_q.mode.full && st_q.cnt == last_idx) begin
                st_d.act = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{act: 1'b0, cnt: '0, start: '0, bank: '0,
                      mode: '0, cl: CL_LO};
        end else begin
            st_q <= st_d;
        end
    end

    assign act   = st_q.act;
    assign cnt   = st_q.cnt;
    assign start = st_q.start;
    assign bank  = st_q.bank;
    assign mode  = st_q.mode;
    assign cl    = st_q.cl;

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !mode.full) |-> (cnt <= last_idx)); // R3

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && !rd_cmd) |=> !act); // R3

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stop && !rd_cmd) |=> !act); // R7

    AST_READ_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd |=> (act && cnt == '0 && start == $past(rd_col))); // R8

endmodule

// File: rtl/sdram_rd_col_gen.sv
module sdram_rd_col_gen
    import sdram_rd_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] cnt,
    input  logic [COL_W-1:0] start,
    input  burst_mode_t      mode,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] blk_mask;
    logic [COL_W-1:0] lin_col;
    logic [COL_W-1:0] xor_col;
    logic [COL_W-1:0] low_part;

    always_comb begin
        blk_mask = (COL_W'(1) << mode.len_log2) - COL_W'(1);
        lin_col  = start + cnt;
        xor_col  = start ^ cnt;
        low_part = mode.intlv ? xor_col : lin_col;
        if (mode.full) begin
            col = lin_col;
        end else begin
            col = (start & ~blk_mask) | (low_part & blk_mask);
        end
    end

endmodule

// File: rtl/sdram_rd_cap_pipe.sv
module sdram_rd_cap_pipe #(
    parameter int DW     = 16,
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int CL_W   = 2,
    parameter int MAX_CL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [COL_W-1:0]  in_col,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [CL_W-1:0]   cl,
    input  logic [DW-1:0]     dq_in,
    output logic              out_vld,
    output logic [DW-1:0]     out_data,
    output logic [COL_W-1:0]  out_col,
    output logic [BANK_W-1:0] out_bank
);

    localparam int NS    = MAX_CL - 1;
    localparam int TAP_W = (NS > 1) ? $clog2(NS) : 1;

    typedef struct packed {
        logic              vld;
        logic [COL_W-1:0]  col;
        logic [BANK_W-1:0] bank;
    } ent_t;

    typedef struct packed {
        ent_t [NS-1:0]     stg;
        logic              vld;
        logic [DW-1:0]     data;
        logic [COL_W-1:0]  col;
        logic [BANK_W-1:0] bank;
    } st_t;

    st_t  st_d, st_q;
    ent_t tap_e;
    logic [TAP_W-1:0] tap_idx;

    assign tap_idx = TAP_W'(cl - CL_W'(2));

    always_comb begin
        st_d            = st_q;
        st_d.stg[0].vld  = in_vld;
        st_d.stg[0].col  = in_col;
        st_d.stg[0].bank = in_bank;
        for (int i = 1; i < NS; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
        tap_e    = st_q.stg[tap_idx];
        st_d.vld = tap_e.vld;
        if (tap_e.vld) begin
            st_d.data = dq_in;
            st_d.col  = tap_e.col;
            st_d.bank = tap_e.bank;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld  = st_q.vld;
    assign out_data = st_q.data;
    assign out_col  = st_q.col;
    assign out_bank = st_q.bank;

    AST_CL2_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && cl == CL_W'(2)) |-> $past(in_vld, 2)); // R2

    AST_CL3_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && cl == CL_W'(3)) |-> $past(in_vld, 3)); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> $stable(out_data)); // R10

endmodule

// File: rtl/sdram_rd_burst_seq.sv
module sdram_rd_burst_seq
    import sdram_rd_pkg::*;
#(
    parameter int DW     = 16,
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int CL_W   = 2,
    parameter int MAX_CL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_cmd,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    input  logic              burst_stop,
    input  logic [2:0]        bl_sel,
    input  logic              intlv_mode,
    input  logic [CL_W-1:0]   cas_lat,
    input  logic [DW-1:0]     dq_in,
    output logic              col_vld,
    output logic [COL_W-1:0]  col_addr,
    output logic [BANK_W-1:0] col_bank,
    output logic              data_vld,
    output logic [DW-1:0]     data_out,
    output logic [COL_W-1:0]  data_col,
    output logic [BANK_W-1:0] data_bank
);

    localparam int MIN_CL = 2;

    logic              b_act;
    logic [COL_W-1:0]  b_cnt;
    logic [COL_W-1:0]  b_start;
    logic [BANK_W-1:0] b_bank;
    burst_mode_t       b_mode;
    logic [CL_W-1:0]   b_cl;
    logic [COL_W-1:0]  b_col;

    sdram_rd_burst_ctl #(
        .COL_W  (COL_W),
        .BANK_W (BANK_W),
        .CL_W   (CL_W),
        .MIN_CL (MIN_CL),
        .MAX_CL (MAX_CL)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_cmd     (rd_cmd),
        .burst_stop (burst_stop),
        .rd_bank    (rd_bank),
        .rd_col     (rd_col),
        .bl_sel     (bl_sel),
        .intlv_mode (intlv_mode),
        .cas_lat    (cas_lat),
        .act        (b_act),
        .cnt        (b_cnt),
        .start      (b_start),
        .bank       (b_bank),
        .mode       (b_mode),
        .cl         (b_cl)
    );

    sdram_rd_col_gen #(
        .COL_W (COL_W)
    ) u_col (
        .cnt   (b_cnt),
        .start (b_start),
        .mode  (b_mode),
        .col   (b_col)
    );

    sdram_rd_cap_pipe #(
        .DW     (DW),
        .COL_W  (COL_W),
        .BANK_W (BANK_W),
        .CL_W   (CL_W),
        .MAX_CL (MAX_CL)
    ) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (b_act),
        .in_col   (b_col),
        .in_bank  (b_bank),
        .cl       (b_cl),
        .dq_in    (dq_in),
        .out_vld  (data_vld),
        .out_data (data_out),
        .out_col  (data_col),
        .out_bank (data_bank)
    );

    assign col_vld  = b_act;
    assign col_addr = b_col;
    assign col_bank = b_bank;

    AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (col_vld && b_mode.full && $past(col_vld) && !$past(rd_cmd))
        |-> (col_addr == $past(col_addr) + COL_W'(1))); // R6

endmodule

// File: tb/tb_sdram_rd_burst_seq.sv
module tb_sdram_rd_burst_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_cmd = 1'b0;
    logic [1:0]  rd_bank = '0;
    logic [7:0]  rd_col = '0;
    logic        burst_stop = 1'b0;
    logic [2:0]  bl_sel = '0;
    logic        intlv_mode = 1'b0;
    logic [1:0]  cas_lat = 2'd2;
    logic [15:0] dq_in = '0;
    logic        col_vld;
    logic [7:0]  col_addr;
    logic [1:0]  col_bank;
    logic        data_vld;
    logic [15:0] data_out;
    logic [7:0]  data_col;
    logic [1:0]  data_bank;

    sdram_rd_burst_seq dut (
        .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .rd_bank(rd_bank),
        .rd_col(rd_col), .burst_stop(burst_stop), .bl_sel(bl_sel),
        .intlv_mode(intlv_mode), .cas_lat(cas_lat), .dq_in(dq_in),
        .col_vld(col_vld), .col_addr(col_addr), .col_bank(col_bank),
        .data_vld(data_vld), .data_out(data_out), .data_col(data_col),
        .data_bank(data_bank)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;
    string cur_req = "R3";

    // behavioural reference state
    bit m_act = 0;
    int m_cnt, m_start, m_bank, m_len, m_cl;
    bit m_full, m_intl;
    bit e_cv = 0;
    int e_cc, e_cb;
    bit e_dv = 0;
    int e_dd, e_dc, e_db;
    bit cap_v[int];
    int cap_c[int];
    int cap_b[int];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s cycle %0d: actual=%0h expected=%0h",
                     tag, what, cyc, act, exp);
        end
    endtask

    function automatic int model_col();
        int base, off, lo;
        if (m_full) return (m_start + m_cnt) % 256;
        lo   = m_start % m_len;
        base = m_start - lo;
        off  = m_intl ? (lo ^ m_cnt) : ((lo + m_cnt) % m_len);
        return base + off;
    endfunction

    // predicts the outputs that follow the coming edge
    task automatic model_edge();
        int c;
        if (cap_v.exists(cyc)) begin
            e_dv = 1; e_dd = dq_in; e_dc = cap_c[cyc]; e_db = cap_b[cyc];
            cap_v.delete(cyc);
        end else begin
            e_dv = 0;
        end
        if (rd_cmd) begin
            m_act = 1; m_cnt = 0; m_start = rd_col; m_bank = rd_bank;
            m_full = bl_sel[2]; m_len = 1 << bl_sel[1:0];
            m_intl = intlv_mode && !bl_sel[2];
            m_cl = (cas_lat < 2) ? 2 : cas_lat;
        end else if (burst_stop) begin
            m_act = 0;
        end else if (m_act) begin
            if (!m_full && m_cnt == m_len - 1) m_act = 0;
            else m_cnt = (m_cnt + 1) % 256;
        end
        if (m_act) begin
            c = model_col();
            e_cv = 1; e_cc = c; e_cb = m_bank;
            cap_v[cyc + m_cl] = 1; cap_c[cyc + m_cl] = c; cap_b[cyc + m_cl] = m_bank;
        end else begin
            e_cv = 0;
        end
    endtask

    task automatic compare();
        chk(col_vld == e_cv, cur_req, "col_vld", col_vld, e_cv);
        if (e_cv && col_vld) begin
            chk(col_addr == 8'(e_cc), cur_req, "col_addr", col_addr, e_cc);
            chk(col_bank == 2'(e_cb), cur_req, "col_bank", col_bank, e_cb);
        end
        chk(data_vld == e_dv, "R2", "data_vld", data_vld, e_dv);
        if (e_dv && data_vld) begin
            chk(data_out == 16'(e_dd), "R10", "data_out", data_out, e_dd);
            chk(data_col == 8'(e_dc), "R10", "data_col", data_col, e_dc);
            chk(data_bank == 2'(e_db), "R10", "data_bank", data_bank, e_db);
        end
    endtask

    task automatic tick();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        cyc++;
        compare();
        dq_in = 16'((cyc * 16'h03B1) ^ 16'hA5C3);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic issue(input int bank, input int col, input int bl,
                         input bit il, input int cl);
        rd_cmd = 1; rd_bank = 2'(bank); rd_col = 8'(col);
        bl_sel = 3'(bl); intlv_mode = il; cas_lat = 2'(cl);
        tick();
        rd_cmd = 0;
    endtask

    task automatic latency_probe(input int expect_cl);
        int k;
        k = 0;
        while (!data_vld && k < 10) begin
            tick();
            k++;
        end
        chk(k == expect_cl, "R2", "first data latency", k, expect_cl);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(col_vld == 0 && data_vld == 0, "R1", "outputs in reset",
            {col_vld, data_vld}, 0);
        rst_n = 1;
        @(posedge clk);
        @(negedge clk);
        chk(col_vld == 0 && data_vld == 0, "R1", "outputs after reset",
            {col_vld, data_vld}, 0);

        // R4: sequential BL4 from column 0x06 (6,7,4,5), CL2
        cur_req = "R4";
        issue(1, 8'h06, 2, 0, 2);
        latency_probe(2);
        idle(6);

        // R5: interleaved BL8 from column 0x2B, CL3
        cur_req = "R5";
        issue(2, 8'h2B, 3, 1, 3);
        latency_probe(3);
        idle(10);

        // R3: BL1 and BL2, sequential and interleaved, clamped latency code 1
        cur_req = "R3";
        issue(0, 8'h11, 0, 0, 1);
        idle(4);
        issue(3, 8'h33, 1, 1, 2);
        idle(4);
        issue(1, 8'h7F, 3, 0, 2);
        idle(10);

        // R6/R7: full page across the 255 -> 0 rollover, then stop
        cur_req = "R6";
        issue(2, 8'hFB, 7, 1, 3);
        idle(9);
        cur_req = "R7";
        burst_stop = 1;
        tick();
        burst_stop = 0;
        idle(6);

        // R7: fixed burst cut short
        issue(0, 8'h40, 3, 0, 3);
        idle(2);
        burst_stop = 1;
        tick();
        burst_stop = 0;
        idle(6);

        // R8: a read replaces a running burst
        cur_req = "R8";
        issue(1, 8'h10, 3, 0, 2);
        idle(2);
        issue(3, 8'h45, 2, 1, 2);
        idle(8);

        // R11: read and stop together during a full page burst
        cur_req = "R11";
        issue(0, 8'h80, 4, 0, 2);
        idle(3);
        burst_stop = 1;
        issue(2, 8'hA2, 1, 0, 2);
        burst_stop = 0;
        idle(6);

        // R9: mode inputs moved during a burst
        cur_req = "R9";
        issue(3, 8'h5D, 3, 0, 3);
        bl_sel = 3'd7; intlv_mode = 1; cas_lat = 2'd2;
        idle(4);
        bl_sel = 3'd0; intlv_mode = 0; cas_lat = 2'd3;
        idle(8);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule